// File: doc/BRIEF.md
# Address Trigger Compare Register

This block is one debug trigger that keeps a single compare address and watches the stream of instruction fetch and load/store effective addresses for it. Software reaches the compare value through a small register-style port. Any value may be written there. The block keeps only a legal form of it, and that form is what software reads back. Every address that is valid as a physical or a virtual address reads back exactly, bit for bit across the full XLEN width, even though fewer bits than XLEN are stored.

The stored field is one bit wider than the wider of the two supported address widths. When read, it is sign-extended. A written value whose high bits cannot be rebuilt from that field becomes a different invalid address, chosen so that it can be stored. A build-time option uses an inhibit policy instead. Under that policy an invalid write stores zero and sets a flag that blocks matching. Under the same policy, an access address that is invalid for the current translation mode never matches. Each accepted access address is legalised the same way as a write. The result is compared with the stored value, and the hit output is registered.

Top module: `addr_trig_cmp`

## Requirements
- R1: After reset the compare value reads back as zero and `hit` is low.
- R2: In physical mode (`trans_virt`=0), a write whose bits above PA_W are all zero reads back exactly as written.
- R3: In virtual mode (`trans_virt`=1), a write whose bits from VA_W-1 to XLEN-1 are all equal reads back exactly as written.
- R4: The stored field has SW = max(PA_W,VA_W)+1 bits. In the default policy, any write whose bits SW-1 to XLEN-1 are all equal is stored as-is, including invalid addresses.
- R5: In the default policy, a write whose bits SW-1 to XLEN-1 differ is stored as bit SW-1 = 1, bit SW-2 = 0, and bits SW-3..0 taken from the write. It reads back as that value sign-extended.
- R6: Read data is always the stored field sign-extended to XLEN bits.
- R7: An access with `csr_en`=1 and `csr_idx` other than CMP_IDX raises `csr_illegal` in the same cycle, returns zero read data and changes no state.
- R8: `hit` rises on the clock edge after a cycle with `m_valid`=1 in which the legalised `m_addr` equals the stored value.
- R9: `hit` stays low after any cycle with `m_valid`=0.
- R10: With INHIBIT_INVALID=1, a write that is invalid for the mode given at write time stores zero and blocks all hits until the next valid write.
- R11: With INHIBIT_INVALID=1, an access address that is invalid for the current mode never hits.
- R12: When a write and a match fall in the same cycle, the match uses the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trans_virt | input | 1 | 1 = virtual translation mode, 0 = physical |
| csr_en | input | 1 | Register access strobe |
| csr_we | input | 1 | Write when set, read otherwise |
| csr_idx | input | IDX_W | Register index of the access |
| csr_wdata | input | XLEN | Write value |
| csr_rdata | output | XLEN | Legal compare value, zero unless the access is legal |
| csr_illegal | output | 1 | Access targets an unimplemented index |
| m_valid | input | 1 | Access address is present |
| m_addr | input | XLEN | Fetch or load/store effective address |
| hit | output | 1 | Registered match result |

## Verification
The assertions assume that `trans_virt` is stable across a write and the read that checks it, that `csr_we` only matters while `csr_en` is high, and that the parameters satisfy SW ≤ XLEN with PA_W and VA_W below XLEN. The bench drives every input at the falling edge and holds the mode steady across each write–read pair. It sets `csr_we` only together with `csr_en` and uses only the default widths. The exact readback assertions therefore see one stable mode for each write.

// File: rtl/addr_trig_cmp.sv
module addr_trig_cmp #(
  parameter int XLEN            = 64,
  parameter int PA_W            = 56,
  parameter int VA_W            = 48,
  parameter int IDX_W           = 4,
  parameter int CMP_IDX         = 3,
  parameter bit INHIBIT_INVALID = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trans_virt,
  input  logic             csr_en,
  input  logic             csr_we,
  input  logic [IDX_W-1:0] csr_idx,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  output logic             csr_illegal,
  input  logic             m_valid,
  input  logic [XLEN-1:0]  m_addr,
  output logic             hit
);
  localparam int MAXW = (PA_W > VA_W) ? PA_W : VA_W;
  localparam int SW   = MAXW + 1;

  function automatic logic fits(input logic [XLEN-1:0] a);
    return (a[XLEN-1:SW-1] == '0) || (a[XLEN-1:SW-1] == '1);
  endfunction

  function automatic logic [SW-1:0] squash(input logic [XLEN-1:0] a);
    return fits(a) ? a[SW-1:0] : {1'b1, 1'b0, a[SW-3:0]};
  endfunction

  function automatic logic addr_ok(input logic [XLEN-1:0] a, input logic virt);
    if (virt) return (a[XLEN-1:VA_W-1] == '0) || (a[XLEN-1:VA_W-1] == '1);
    return a[XLEN-1:PA_W] == '0;
  endfunction

  logic [SW-1:0]   cmp_q, cmp_d;
  logic            inv_q, inv_d;
  logic            hit_q, gate;
  logic [XLEN-1:0] rd_full;
  logic            sel, wr_go;

  assign sel         = csr_idx == IDX_W'(CMP_IDX);
  assign wr_go       = csr_en & csr_we & sel;
  assign csr_illegal = csr_en & ~sel;
  assign rd_full     = XLEN'($signed(cmp_q));
  assign csr_rdata   = (csr_en & sel) ? rd_full : '0;

  generate
    if (INHIBIT_INVALID) begin : g_inhibit
      logic w_ok;
      assign w_ok  = addr_ok(csr_wdata, trans_virt);
      assign cmp_d = w_ok ? csr_wdata[SW-1:0] : '0;
      assign inv_d = ~w_ok;
      assign gate  = ~inv_q & addr_ok(m_addr, trans_virt);
    end else begin : g_store
      assign cmp_d = squash(csr_wdata);
      assign inv_d = 1'b0;
      assign gate  = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      inv_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      if (wr_go) begin
        cmp_q <= cmp_d;
        inv_q <= inv_d;
      end
      hit_q <= m_valid & gate & (squash(m_addr) == cmp_q);
    end
  end

  assign hit = hit_q;
endmodule

module addr_trig_cmp_chk #(
  parameter int XLEN            = 64,
  parameter int PA_W            = 56,
  parameter int VA_W            = 48,
  parameter int IDX_W           = 4,
  parameter bit INHIBIT_INVALID = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trans_virt,
  input logic             csr_en,
  input logic             csr_we,
  input logic             csr_illegal,
  input logic [XLEN-1:0]  csr_wdata,
  input logic             m_valid,
  input logic             hit,
  input logic             inv_q,
  input logic [XLEN-1:0]  rd_full
);
  localparam int MAXW = (PA_W > VA_W) ? PA_W : VA_W;
  localparam int SW   = MAXW + 1;

  logic wr_ok, phys_ok, virt_ok, repr;
  assign wr_ok   = csr_en & csr_we & ~csr_illegal;
  assign phys_ok = csr_wdata[XLEN-1:PA_W] == '0;
  assign virt_ok = (csr_wdata[XLEN-1:VA_W-1] == '0) || (csr_wdata[XLEN-1:VA_W-1] == '1);
  assign repr    = (csr_wdata[XLEN-1:SW-1] == '0) || (csr_wdata[XLEN-1:SW-1] == '1);

  // R2
  phys_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !trans_virt && phys_ok) |=> (rd_full == $past(csr_wdata)));
  // R3
  virt_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && trans_virt && virt_ok) |=> (rd_full == $past(csr_wdata)));
  // R5
  squash_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!INHIBIT_INVALID && wr_ok && !repr) |=> (rd_full[XLEN-1] && !rd_full[SW-2]));
  // R7
  illegal_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en && csr_illegal) |=> $stable(rd_full));
  // R9
  hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(m_valid));
  // R10
  inhibit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_q && m_valid) |=> !hit);
  // R10
  inhibit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (INHIBIT_INVALID && wr_ok && !(trans_virt ? virt_ok : phys_ok)) |=> (rd_full == '0));
endmodule

bind addr_trig_cmp addr_trig_cmp_chk #(
  .XLEN(XLEN), .PA_W(PA_W), .VA_W(VA_W), .IDX_W(IDX_W), .INHIBIT_INVALID(INHIBIT_INVALID)
) chk_i (
  .clk(clk), .rst_n(rst_n), .trans_virt(trans_virt), .csr_en(csr_en), .csr_we(csr_we),
  .csr_illegal(csr_illegal), .csr_wdata(csr_wdata), .m_valid(m_valid), .hit(hit),
  .inv_q(inv_q), .rd_full(rd_full)
);

// File: tb/addr_trig_cmp_tb.sv
module addr_trig_cmp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trans_virt = 1'b0;
  logic        csr_en = 1'b0;
  logic        csr_we = 1'b0;
  logic [3:0]  csr_idx = 4'd3;
  logic [63:0] csr_wdata = '0;
  logic        m_valid = 1'b0;
  logic [63:0] m_addr = '0;
  logic [63:0] rd_s, rd_i;
  logic        ill_s, ill_i, hit_s, hit_i;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  addr_trig_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .trans_virt(trans_virt), .csr_en(csr_en), .csr_we(csr_we),
    .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(rd_s), .csr_illegal(ill_s),
    .m_valid(m_valid), .m_addr(m_addr), .hit(hit_s));

  addr_trig_cmp #(.INHIBIT_INVALID(1'b1)) dut_inh_i (
    .clk(clk), .rst_n(rst_n), .trans_virt(trans_virt), .csr_en(csr_en), .csr_we(csr_we),
    .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(rd_i), .csr_illegal(ill_i),
    .m_valid(m_valid), .m_addr(m_addr), .hit(hit_i));

  localparam int NV = 12;
  localparam logic [63:0] VW [NV] = '{
    64'h0000_0000_0000_1000, 64'h00FF_FFFF_FFFF_FFFC, 64'hFFFF_FFFF_FFFF_F000,
    64'h0000_7FFF_FFFF_FFF0, 64'hFFFF_8000_0000_0000, 64'h8000_0000_0000_0000,
    64'h1234_5678_9ABC_DEF0, 64'h0100_0000_0000_0000, 64'hFE00_0000_0000_0001,
    64'h00FF_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF7F_FFFF_0000_0000};
  localparam logic [63:0] VE [NV] = '{
    64'h0000_0000_0000_1000, 64'h00FF_FFFF_FFFF_FFFC, 64'hFFFF_FFFF_FFFF_F000,
    64'h0000_7FFF_FFFF_FFF0, 64'hFFFF_8000_0000_0000, 64'hFF00_0000_0000_0000,
    64'hFF34_5678_9ABC_DEF0, 64'hFF00_0000_0000_0000, 64'hFF00_0000_0000_0001,
    64'h00FF_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFF7F_FFFF_0000_0000};
  localparam bit VM [NV] = '{0, 0, 1, 1, 1, 0, 0, 0, 1, 1, 1, 0};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [63:0] d, input logic virt);
    @(negedge clk);
    csr_en = 1; csr_we = 1; csr_idx = idx; csr_wdata = d; trans_virt = virt;
    @(negedge clk);
    csr_en = 0; csr_we = 0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [63:0] s, output logic [63:0] i,
                    output logic ils);
    @(negedge clk);
    csr_en = 1; csr_we = 0; csr_idx = idx;
    #1;
    s = rd_s; i = rd_i; ils = ill_s;
    @(negedge clk);
    csr_en = 0;
  endtask

  task automatic probe(input logic v, input logic [63:0] a, input logic virt,
                       output logic hs, output logic hi);
    @(negedge clk);
    m_valid = v; m_addr = a; trans_virt = virt;
    @(negedge clk);
    m_valid = 0;
    hs = hit_s; hi = hit_i;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] s, i;
    logic il, hs, hi;
    repeat (3) @(negedge clk);
    chk("R1 hit in reset", {63'd0, hit_s}, 64'd0);
    rst_n = 1;
    rd(4'd3, s, i, il);
    chk("R1 reset read", s, 64'd0);
    chk("R1 reset read inh", i, 64'd0);

    // R2 R3 R4 R5 R6: vector walk on the default policy
    for (int k = 0; k < NV; k++) begin
      wr(4'd3, VW[k], VM[k]);
      rd(4'd3, s, i, il);
      chk($sformatf("R2/R3/R4/R5/R6 vector %0d", k), s, VE[k]);
    end

    // R7
    wr(4'd3, 64'h1000, 0);
    wr(4'd5, 64'hABC, 0);
    rd(4'd5, s, i, il);
    chk("R7 illegal flag", {63'd0, il}, 64'd1);
    chk("R7 illegal rdata", s, 64'd0);
    rd(4'd3, s, i, il);
    chk("R7 value kept", s, 64'h1000);
    chk("R7 legal no flag", {63'd0, il}, 64'd0);

    // R8 R9
    probe(1, 64'h1000, 0, hs, hi);
    chk("R8 equal hit", {63'd0, hs}, 64'd1);
    probe(1, 64'h1004, 0, hs, hi);
    chk("R8 differ no hit", {63'd0, hs}, 64'd0);
    probe(0, 64'h1000, 0, hs, hi);
    chk("R9 no valid", {63'd0, hs}, 64'd0);

    // R5 match through legalisation
    wr(4'd3, 64'h8000_0000_0000_0000, 0);
    probe(1, 64'h8000_0000_0000_0000, 0, hs, hi);
    chk("R5 squashed hit", {63'd0, hs}, 64'd1);
    probe(1, 64'h0100_0000_0000_0000, 0, hs, hi);
    chk("R5 alias hit", {63'd0, hs}, 64'd1);

    // R12
    wr(4'd3, 64'h1000, 0);
    @(negedge clk);
    csr_en = 1; csr_we = 1; csr_idx = 4'd3; csr_wdata = 64'h2000;
    m_valid = 1; m_addr = 64'h2000;
    @(negedge clk);
    csr_en = 0; csr_we = 0; m_valid = 0;
    chk("R12 old value used", {63'd0, hit_s}, 64'd0);
    probe(1, 64'h2000, 0, hs, hi);
    chk("R12 new value", {63'd0, hs}, 64'd1);

    // R10 R11 inhibit policy
    wr(4'd3, 64'h1000, 0);
    probe(1, 64'h1000, 0, hs, hi);
    chk("R10 valid hit inh", {63'd0, hi}, 64'd1);
    wr(4'd3, 64'h0100_0000_0000_0000, 0);
    rd(4'd3, s, i, il);
    chk("R10 invalid phys stored zero", i, 64'd0);
    probe(1, 64'h0, 0, hs, hi);
    chk("R10 flag blocks", {63'd0, hi}, 64'd0);
    wr(4'd3, 64'h0000_8000_0000_0000, 1);
    rd(4'd3, s, i, il);
    chk("R10 invalid virt stored zero", i, 64'd0);
    chk("R4 representable kept", s, 64'h0000_8000_0000_0000);
    wr(4'd3, 64'h0, 1);
    probe(1, 64'h0, 1, hs, hi);
    chk("R10 flag cleared", {63'd0, hi}, 64'd1);
    wr(4'd3, 64'h00FF_0000_0000_0000, 0);
    probe(1, 64'h00FF_0000_0000_0000, 1, hs, hi);
    chk("R11 invalid access inh", {63'd0, hi}, 64'd0);
    chk("R4 store policy matches", {63'd0, hs}, 64'd1);
    probe(1, 64'h00FF_0000_0000_0000, 0, hs, hi);
    chk("R11 valid access inh", {63'd0, hi}, 64'd1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule